// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface and brings the memory from reset to a usable state. After reset it holds the clock-enable pin low for a programmed settling time. It then raises clock-enable while idling with no-operation commands. Next it walks through a fixed command list on the chip-select, row-strobe, column-strobe, write-enable, bank and address pins. Every delay is a count of controller clocks that the integrator sets from the clock frequency.

The first precharge-all is followed by the extended mode registers 2 and 3. Next come the extended mode register with the DLL enabled and the mode register with DLL reset. A second precharge-all and a configurable number of refreshes follow. The mode register is then written again with DLL reset cleared, and the output-driver calibration bits are set to their default and then cleared. The completion flag rises only once the final register write has settled and the DLL lock window, counted from the DLL-reset write, has elapsed. Downstream logic must not issue reads before that. Mode-register payloads are parameters. The block forces only the DLL-reset bit and the calibration field (address bits 9:7).

Top module: `ddr2_init_seq`

## Requirements
- R1: Reset is synchronous and active low, and acts from any state. While it is asserted, and for T_PWR cycles after the first clock edge with it released, cke is 0, the command pins show no-operation ({cs_n,ras_n,cas_n,we_n} = 4'b0111) and init_done is 0.
- R2: cke rises at exactly T_PWR clock edges after reset release. Exactly T_CKE cycles of no-operation then pass before the first command.
- R3: Each precharge-all drives 4'b0010 with address bit 10 set and all other address bits 0. There are two of them. The next command follows T_RPA cycles later.
- R4: Every load-mode command drives 4'b0000 for one cycle. The bank pins select the register: 0 is the mode register, 1 the extended register, 2 extended register 2, 3 extended register 3. The next command follows T_MRD cycles later. The first four load-mode commands go to banks 2, 3, 1, 0 in that order.
- R5: The DLL-enable write to bank 1 carries EMR_VAL with address bits 9:7 cleared.
- R6: The first mode-register write carries MR_VAL with bit DLLRST_BIT set. The later one carries MR_VAL with that bit cleared.
- R7: After the DLL-reset write, a second precharge-all is followed by N_REF refresh commands (4'b0001, address 0). Each refresh is followed by T_RFC cycles before the next command. The mode-register write without DLL reset comes next.
- R8: After it come two writes to bank 1: EMR_VAL with bits 9:7 set (calibration default), then EMR_VAL with bits 9:7 cleared (calibration exit).
- R9: init_done rises one cycle after the later of two points: T_MRD cycles after the calibration-exit command, and T_LOCK+1 cycles after the DLL-reset command. It is therefore never high within T_LOCK cycles of that command.
- R10: Once high, init_done stays high with cke high and no-operation on the command pins until reset.
- R11: Every command lasts exactly one cycle, and all other cycles show no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address / mode register select |
| addr | output | ADDR_W | Address bus and mode payload |
| init_done | output | 1 | Initialization complete, reads allowed |

## Verification
The pins are decoded from registered state, so each result appears in a fixed cycle after the event that causes it. cke rises T_PWR edges after reset release. Each command follows the previous one by that command's wait count, and the done flag follows the rule in R9. The bench counts clock edges from reset release and samples on the falling edge. It records the cycle of every command and compares each spacing, command code, bank and address with values it derives from its own parameters. It computes the expected completion cycle from the recorded DLL-reset and calibration-exit cycles. It also checks that reset mid-sequence and after completion returns the pins to the low-clock-enable idle state on the next sample.

// File: rtl/ddr2i_pkg.sv
// Shared types for the DDR2 initialization sequencer.
// Assumes: command pins are ordered {cs_n, ras_n, cas_n, we_n}.
package ddr2i_pkg;

    // Sequencer steps in issue order; the order is behaviour, not layout.
    typedef enum logic [3:0] {
        ST_PWR,          // cke low, settling wait
        ST_CKE,          // cke high, idle before first precharge
        ST_PRE1,         // precharge-all #1
        ST_EMR2,         // extended register 2
        ST_EMR3,         // extended register 3
        ST_EMR_DLL,      // extended register, DLL enabled
        ST_MR_DLLRST,    // mode register with DLL reset
        ST_PRE2,         // precharge-all #2
        ST_REF,          // refresh, repeated
        ST_MR_RUN,       // mode register without DLL reset
        ST_EMR_OCDDEF,   // calibration default
        ST_EMR_OCDEXIT,  // calibration exit
        ST_LOCKWAIT,     // wait for DLL lock window
        ST_DONE          // initialized
    } step_t;

    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_LMR = 4'b0000;

endpackage

// File: rtl/ddr2i_down_counter.sv
// Shared wait counter: loaded on every step change, counts down to zero.
// Assumes: load is asserted during reset, so no separate reset is needed.
module ddr2i_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load on demand, otherwise decrement and hold at zero.
    always_ff @(posedge clk) begin
        if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr2i_lock_timer.sv
// DLL lock window: counts T_LOCK cycles after the DLL-reset write.
// Assumes: start_i pulses for one cycle; a later pulse restarts the window.
module ddr2i_lock_timer #(
    parameter int T_LOCK = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int LK_W = $clog2(T_LOCK + 1);

    logic            armed_q;
    logic [LK_W-1:0] cnt_q;

    // Arm on start, then count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (start_i) begin
            armed_q <= 1'b1;
            cnt_q   <= LK_W'(T_LOCK);
        end else if (armed_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/ddr2i_cmd_decode.sv
// Pin decode: turns the current step into cke, command, bank and address.
// Assumes: a command is driven only in the first cycle of its step (fresh_i);
// ADDR_W is at least 11 and DLLRST_BIT lies inside the address bus.
module ddr2i_cmd_decode
    import ddr2i_pkg::*;
#(
    parameter int                ADDR_W     = 14,
    parameter int                BA_W       = 3,
    parameter int                DLLRST_BIT = 8,
    parameter logic [ADDR_W-1:0] MR_VAL     = '0,
    parameter logic [ADDR_W-1:0] EMR_VAL    = '0,
    parameter logic [ADDR_W-1:0] EMR2_VAL   = '0,
    parameter logic [ADDR_W-1:0] EMR3_VAL   = '0
) (
    input  step_t             step_i,
    input  logic              fresh_i,
    output logic              cke_o,
    output logic [3:0]        cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A10_ALL  = ONE << 10;
    localparam logic [ADDR_W-1:0] OCD_MASK = (ONE << 7) | (ONE << 8) | (ONE << 9);
    localparam logic [ADDR_W-1:0] DLL_MASK = ONE << DLLRST_BIT;

    // Drive the step's command in its first cycle, no-operation otherwise.
    always_comb begin
        cke_o  = (step_i != ST_PWR);
        cmd_o  = CMD_NOP;
        ba_o   = '0;
        addr_o = '0;
        if (fresh_i) begin
            case (step_i)
                ST_PRE1, ST_PRE2: begin
                    cmd_o  = CMD_PRE;
                    addr_o = A10_ALL;
                end
                ST_EMR2: begin
                    cmd_o  = CMD_LMR;
                    ba_o   = BA_W'(2);
                    addr_o = EMR2_VAL;
                end
                ST_EMR3: begin
                    cmd_o  = CMD_LMR;
                    ba_o   = BA_W'(3);
                    addr_o = EMR3_VAL;
                end
                ST_EMR_DLL, ST_EMR_OCDEXIT: begin
                    cmd_o  = CMD_LMR;
                    ba_o   = BA_W'(1);
                    addr_o = EMR_VAL & ~OCD_MASK;
                end
                ST_EMR_OCDDEF: begin
                    cmd_o  = CMD_LMR;
                    ba_o   = BA_W'(1);
                    addr_o = EMR_VAL | OCD_MASK;
                end
                ST_MR_DLLRST: begin
                    cmd_o  = CMD_LMR;
                    addr_o = MR_VAL | DLL_MASK;
                end
                ST_MR_RUN: begin
                    cmd_o  = CMD_LMR;
                    addr_o = MR_VAL & ~DLL_MASK;
                end
                ST_REF: cmd_o = CMD_REF;
                default: cmd_o = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 power-up initialization sequencer (top).
// Walks the fixed precharge / load-mode / refresh list, spacing commands with
// one shared down-counter reloaded at every step change, and raises init_done
// once the DLL lock window has elapsed. Assumes all waits are at least 1 and
// N_REF is at least 1.
module ddr2_init_seq
    import ddr2i_pkg::*;
#(
    parameter int                ADDR_W     = 14,
    parameter int                BA_W       = 3,
    parameter int                T_PWR      = 80000,
    parameter int                T_CKE      = 160,
    parameter int                T_RPA      = 6,
    parameter int                T_MRD      = 2,
    parameter int                T_RFC      = 51,
    parameter int                T_LOCK     = 200,
    parameter int                N_REF      = 2,
    parameter int                DLLRST_BIT = 8,
    parameter logic [ADDR_W-1:0] MR_VAL     = ADDR_W'(14'h0a52),
    parameter logic [ADDR_W-1:0] EMR_VAL    = ADDR_W'(14'h0004),
    parameter logic [ADDR_W-1:0] EMR2_VAL   = '0,
    parameter logic [ADDR_W-1:0] EMR3_VAL   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int MAX_A = (T_PWR > T_CKE) ? T_PWR : T_CKE;
    localparam int MAX_B = (T_RPA > T_RFC) ? T_RPA : T_RFC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_W = (MAX_C > T_MRD) ? MAX_C : T_MRD;
    localparam int CNT_W = $clog2(MAX_W + 1);
    localparam int RF_W  = $clog2(N_REF + 1);

    step_t            step_q, step_nxt;
    logic             fresh_q;
    logic             advance;
    logic             cnt_zero;
    logic             cnt_load;
    logic [CNT_W-1:0] load_val;
    logic [RF_W-1:0]  ref_q;
    logic             lock_start;
    logic             lock_done;
    logic [3:0]       cmd;

    // Wait length, minus one, that a step holds before the next command.
    function automatic logic [CNT_W-1:0] wait_of(input step_t s);
        case (s)
            ST_PWR:            wait_of = CNT_W'(T_PWR - 1);
            ST_CKE:            wait_of = CNT_W'(T_CKE - 1);
            ST_PRE1, ST_PRE2:  wait_of = CNT_W'(T_RPA - 1);
            ST_REF:            wait_of = CNT_W'(T_RFC - 1);
            ST_EMR2, ST_EMR3, ST_EMR_DLL, ST_MR_DLLRST,
            ST_MR_RUN, ST_EMR_OCDDEF, ST_EMR_OCDEXIT:
                               wait_of = CNT_W'(T_MRD - 1);
            default:           wait_of = '0;
        endcase
    endfunction

    // Choose the next step when the current wait has run out.
    always_comb begin
        advance  = 1'b0;
        step_nxt = step_q;
        case (step_q)
            ST_LOCKWAIT: begin
                if (lock_done) begin
                    advance  = 1'b1;
                    step_nxt = ST_DONE;
                end
            end
            ST_DONE: advance = 1'b0;
            default: begin
                if (cnt_zero) begin
                    advance = 1'b1;
                    case (step_q)
                        ST_PWR:         step_nxt = ST_CKE;
                        ST_CKE:         step_nxt = ST_PRE1;
                        ST_PRE1:        step_nxt = ST_EMR2;
                        ST_EMR2:        step_nxt = ST_EMR3;
                        ST_EMR3:        step_nxt = ST_EMR_DLL;
                        ST_EMR_DLL:     step_nxt = ST_MR_DLLRST;
                        ST_MR_DLLRST:   step_nxt = ST_PRE2;
                        ST_PRE2:        step_nxt = ST_REF;
                        ST_REF:         step_nxt = (ref_q == RF_W'(N_REF - 1))
                                                   ? ST_MR_RUN : ST_REF;
                        ST_MR_RUN:      step_nxt = ST_EMR_OCDDEF;
                        ST_EMR_OCDDEF:  step_nxt = ST_EMR_OCDEXIT;
                        ST_EMR_OCDEXIT: step_nxt = ST_LOCKWAIT;
                        default:        step_nxt = ST_DONE;
                    endcase
                end
            end
        endcase
    end

    // Reload the shared counter on reset and on every step change.
    assign cnt_load = !rst_n || advance;
    assign load_val = rst_n ? wait_of(step_nxt) : wait_of(ST_PWR);

    ddr2i_down_counter #(.W(CNT_W)) u_wait (
        .clk        (clk),
        .load_i     (cnt_load),
        .load_val_i (load_val),
        .zero_o     (cnt_zero)
    );

    // Step register, first-cycle flag and refresh tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= ST_PWR;
            fresh_q <= 1'b1;
            ref_q   <= '0;
        end else begin
            if (advance)
                step_q <= step_nxt;
            fresh_q <= advance;
            if (step_q == ST_REF && advance)
                ref_q <= ref_q + 1'b1;
        end
    end

    assign lock_start = (step_q == ST_MR_DLLRST) && fresh_q;

    ddr2i_lock_timer #(.T_LOCK(T_LOCK)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (lock_start),
        .done_o  (lock_done)
    );

    ddr2i_cmd_decode #(
        .ADDR_W     (ADDR_W),
        .BA_W       (BA_W),
        .DLLRST_BIT (DLLRST_BIT),
        .MR_VAL     (MR_VAL),
        .EMR_VAL    (EMR_VAL),
        .EMR2_VAL   (EMR2_VAL),
        .EMR3_VAL   (EMR3_VAL)
    ) u_dec (
        .step_i  (step_q),
        .fresh_i (fresh_q),
        .cke_o   (cke),
        .cmd_o   (cmd),
        .ba_o    (ba),
        .addr_o  (addr)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign init_done = (step_q == ST_DONE);
endmodule

// File: rtl/ddr2_init_seq_chk.sv
// Checker bound to ddr2_init_seq: watches only the pins and keeps its own
// counters for command spacing and the DLL lock window.
module ddr2_init_seq_chk #(
    parameter int ADDR_W     = 14,
    parameter int BA_W       = 3,
    parameter int T_MRD      = 2,
    parameter int T_LOCK     = 200,
    parameter int DLLRST_BIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);
    localparam int GW = $clog2(T_MRD + 2) + 1;
    localparam int LW = $clog2(T_LOCK + 2) + 1;

    logic [3:0]    cmd;
    logic          is_cmd, is_dllrst;
    logic [GW-1:0] since_cmd;
    logic          last_lm;
    logic [LW-1:0] since_dll;
    logic          dll_seen;

    assign cmd       = {cs_n, ras_n, cas_n, we_n};
    assign is_cmd    = (cmd != 4'b0111);
    assign is_dllrst = (cmd == 4'b0000) && (ba == '0) && addr[DLLRST_BIT];

    // Cycles since the last command and whether it was a load-mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cmd <= '0;
            last_lm   <= 1'b0;
        end else if (is_cmd) begin
            since_cmd <= GW'(1);
            last_lm   <= (cmd == 4'b0000);
        end else if (since_cmd < GW'(T_MRD)) begin
            since_cmd <= since_cmd + 1'b1;
        end
    end

    // Cycles since the DLL-reset write, saturating at the lock window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_dll <= '0;
            dll_seen  <= 1'b0;
        end else if (is_dllrst) begin
            since_dll <= LW'(1);
            dll_seen  <= 1'b1;
        end else if (dll_seen && since_dll < LW'(T_LOCK)) begin
            since_dll <= since_dll + 1'b1;
        end
    end

    assert_cke_low_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd == 4'b0111 && !init_done));

    assert_pre_all_banks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> (addr == (ADDR_W'(1) << 10)));

    assert_mrd_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && last_lm) |-> (since_cmd >= GW'(T_MRD)));

    assert_lock_before_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (dll_seen && since_dll >= LW'(T_LOCK)));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cke && cmd == 4'b0111));

    assert_cke_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    assert_single_cycle_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |=> !is_cmd);
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
    .ADDR_W     (ADDR_W),
    .BA_W       (BA_W),
    .T_MRD      (T_MRD),
    .T_LOCK     (T_LOCK),
    .DLLRST_BIT (DLLRST_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/ddr2_init_seq_tb.sv
// Directed bench for ddr2_init_seq with shortened wait counts.
module ddr2_init_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 14;
    localparam int BA_W   = 3;
    localparam int T_PWR  = 20;
    localparam int T_CKE  = 8;
    localparam int T_RPA  = 3;
    localparam int T_MRD  = 2;
    localparam int T_RFC  = 5;
    localparam int T_LOCK = 30;
    localparam int N_REF  = 2;
    localparam int NCMD   = 11;
    localparam logic [ADDR_W-1:0] MR_V   = 14'h0563;
    localparam logic [ADDR_W-1:0] EMR_V  = 14'h02c6;
    localparam logic [ADDR_W-1:0] EMR2_V = 14'h0080;
    localparam logic [ADDR_W-1:0] EMR3_V = 14'h0001;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ddr2_init_seq #(
        .ADDR_W (ADDR_W), .BA_W (BA_W), .T_PWR (T_PWR), .T_CKE (T_CKE),
        .T_RPA (T_RPA), .T_MRD (T_MRD), .T_RFC (T_RFC), .T_LOCK (T_LOCK),
        .N_REF (N_REF), .DLLRST_BIT (8), .MR_VAL (MR_V), .EMR_VAL (EMR_V),
        .EMR2_VAL (EMR2_V), .EMR3_VAL (EMR3_V)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
        .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr),
        .init_done (init_done)
    );

    function automatic logic [3:0] pins();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected command list: code, bank, address, spacing from the previous event.
    function automatic logic [3:0] e_cmd(input int i);
        if (i == 0 || i == 5) return 4'b0010;
        if (i == 6 || i == 7) return 4'b0001;
        return 4'b0000;
    endfunction
    function automatic int e_ba(input int i);
        case (i)
            1: return 2;
            2: return 3;
            3, 9, 10: return 1;
            default: return 0;
        endcase
    endfunction
    function automatic logic [ADDR_W-1:0] e_addr(input int i);
        case (i)
            0, 5: return 14'h0400;
            1: return EMR2_V;
            2: return EMR3_V;
            3, 10: return EMR_V & ~14'h0380;
            4: return MR_V | 14'h0100;
            8: return MR_V & ~14'h0100;
            9: return EMR_V | 14'h0380;
            default: return '0;
        endcase
    endfunction
    function automatic int e_gap(input int i);
        case (i)
            0: return T_CKE;
            1, 6: return T_RPA;
            7, 8: return T_RFC;
            default: return T_MRD;
        endcase
    endfunction
    function automatic string e_req(input int i);
        case (i)
            0, 5: return "R3";
            3: return "R5";
            4, 8: return "R6";
            6, 7: return "R7";
            9, 10: return "R8";
            default: return "R4";
        endcase
    endfunction

    // R1: pins idle with cke low while reset is held.
    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "cke in reset", cke, 0);
        chk("R1", "cmd in reset", pins(), 4'b0111);
        chk("R1", "init_done in reset", init_done, 0);
    endtask

    // R1-R9 via R2..R9 tags: release reset and follow the whole sequence.
    task automatic t_full_sequence();
        int n = 0;
        int idx = 0;
        int last = 0;
        int t_m = 0;
        int t_x = 0;
        int exp_done;
        bit cke_seen = 0;
        rst_n = 1'b1;
        while (n < 2000) begin
            if (!cke) begin
                chk("R1", "cmd while cke low", pins(), 4'b0111);
            end else if (!cke_seen) begin
                cke_seen = 1;
                last = n;
                chk("R2", "cke rise cycle", n, T_PWR);
            end
            if (init_done) break;
            if (pins() != 4'b0111) begin
                if (idx < NCMD) begin
                    chk(e_req(idx), $sformatf("cmd %0d code", idx), pins(), e_cmd(idx));
                    chk(e_req(idx), $sformatf("cmd %0d bank", idx), ba, e_ba(idx));
                    chk(e_req(idx), $sformatf("cmd %0d addr", idx), addr, e_addr(idx));
                    chk(idx == 0 ? "R2" : e_req(idx - 1),
                        $sformatf("cmd %0d spacing", idx), n - last, e_gap(idx));
                    if (idx == 4) t_m = n;
                    if (idx == 10) t_x = n;
                end else begin
                    chk("R11", "extra command", idx, NCMD - 1);
                end
                last = n;
                idx++;
            end
            @(negedge clk);
            n++;
        end
        chk("R7", "commands issued", idx, NCMD);
        exp_done = ((t_x + T_MRD) > (t_m + T_LOCK + 1) ? (t_x + T_MRD) : (t_m + T_LOCK + 1)) + 1;
        chk("R9", "init_done cycle", n, exp_done);
        chk("R9", "lock window respected", (n - t_m) > T_LOCK, 1);
    endtask

    // R10: held done state with idle pins.
    task automatic t_idle_after_done();
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (k % 10 == 0) begin
                chk("R10", "init_done held", init_done, 1);
                chk("R10", "cke held", cke, 1);
                chk("R10", "idle cmd", pins(), 4'b0111);
            end
        end
    endtask

    // R1: reset taken from the middle of the sequence.
    task automatic t_midway_reset();
        rst_n = 1'b1;
        repeat (T_PWR + T_CKE + 20) @(negedge clk);
        chk("R1", "mid-sequence cke high before reset", cke, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "cke after mid reset", cke, 0);
        chk("R1", "cmd after mid reset", pins(), 4'b0111);
        chk("R1", "init_done after mid reset", init_done, 0);
        @(negedge clk);
    endtask

    // R10: reset after completion clears done.
    task automatic t_reset_after_done();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10", "init_done cleared by reset", init_done, 0);
        chk("R10", "cke cleared by reset", cke, 0);
        @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_full_sequence();
        t_idle_after_done();
        t_reset_after_done();
        t_midway_reset();
        t_full_sequence();
        report();
    end
endmodule